// File: doc/BRIEF.md
# Multiplexed Pixel Port Unpacker

This block sits between a frame-buffer read path and a colour pipeline running at pixel rate. Each wide input word is 96 bits, split into four 24-bit lanes. It carries 2, 4 or 8 pixels, depending on the programmed colour format and multiplex ratio. The block turns that word into a stream of exactly one pixel per clock. Each pixel comes out either as a 24-bit RGB triple or as an 8-bit palette index, with a valid flag.

The block also drives the load strobe that asks the upstream source for the next word. The strobe repeats every 2, 4 or 8 clocks to match the ratio in force. The word and the configuration are sampled together on the one clock edge where the strobe is high. A new format or ratio therefore never splits a word.

Top module: `pix_unpack`

## Requirements
- R1: While `rst` is high, and on the outputs after the last reset edge, `pix_valid_o` is 0, `pix_rgb_o` and `pix_idx_o` are 0, and `load_o` is 1.
- R2: Lane A is `word_in[23:0]`, lane B is `[47:24]`, lane C is `[71:48]` and lane D is `[95:72]`. Within a lane, red is bits `[23:16]`, green is `[15:8]` and blue is `[7:0]`. The word is captured on the rising edge where `load_o` is 1. Its pixel 0 appears in the cycle after that edge. The following pixels appear one per cycle in lane order A, B, C, D.
- R3: `cfg_ratio` selects the pixels per word: code 0 is 2:1 (lanes A and B), code 1 is 4:1, code 2 is 8:1 and code 3 is treated as 2:1. Code 2 with a true-colour format is treated as 4:1.
- R4: `load_o` is high for exactly one cycle in every N cycles, where N is the pixels per word. It is high in the same cycle as the last pixel of the current word.
- R5: Format code 0 (24-bit) outputs the lane unchanged on `pix_rgb_o` as {red, green, blue}.
- R6: Format code 1 (16-bit) reads lane bits `[15:0]` as red `[15:11]`, green `[10:5]` and blue `[4:0]`. Each field is left-aligned to 8 bits, and its low bits are filled with copies of its top bits.
- R7: Format code 2 (15-bit) reads lane bits `[14:0]` as red `[14:10]`, green `[9:5]` and blue `[4:0]`. Each field is widened the same way as in R6.
- R8: Format code 3 (8-bit index) outputs each lane's red byte at 4:1 and 2:1. At 8:1 each lane supplies two indices, its red byte first and then its green byte.
- R9: In index format `pix_rgb_o` is 0. In the true-colour formats `pix_idx_o` is 0.
- R10: `cfg_fmt`, `cfg_ratio` and `word_in` have no effect on the pixel stream except on the edge where `load_o` is 1.
- R11: Once the first word has been captured, `pix_valid_o` stays 1 on every cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Colour format code |
| cfg_ratio | input | 2 | Multiplex ratio code |
| word_in | input | 96 | Four 24-bit lanes, A in the low bits |
| load_o | output | 1 | Word request strobe; the word is taken on the edge where this is high |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_rgb_o | output | 24 | True-colour pixel {red, green, blue} |
| pix_idx_o | output | 8 | Palette index pixel |

## Verification
Three things fall on the same edge: the last pixel of one word leaves, the next word is captured and a new format and ratio are sampled. The bench runs words back to back, each under a different mode, so every boundary changes the decoding and the strobe period at once.

Straight after pixel 0 of every word, the bench scrambles `word_in` and flips the configuration inputs. Every later pixel of that word is compared against the originally captured word and mode. The strobe level is also checked on every pixel cycle, so it must rise exactly with the last pixel.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int PP_LANES  = 4;
  localparam int PP_LANE_W = 24;

  typedef enum logic [1:0] {
    FMT_RGB24 = 2'd0,
    FMT_RGB16 = 2'd1,
    FMT_RGB15 = 2'd2,
    FMT_IDX8  = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [3:0] per_word;
  } mode_t;

  // pixels carried by one word for a format / ratio code pair
  function automatic logic [3:0] pixels_per_word(input fmt_e f, input logic [1:0] r);
    logic [3:0] n;
    case (r)
      2'd1:    n = 4'd4;
      2'd2:    n = (f == FMT_IDX8) ? 4'd8 : 4'd4;
      default: n = 4'd2;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pix_mode_reg.sv
module pix_mode_reg
  import pix_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic [1:0] cfg_fmt,
  input  logic [1:0] cfg_ratio,
  output mode_t      sel_mode,
  output mode_t      cur_mode
);
  mode_t cfg_mode;

  always_comb begin
    cfg_mode.fmt      = fmt_e'(cfg_fmt);
    cfg_mode.per_word = pixels_per_word(fmt_e'(cfg_fmt), cfg_ratio);
    sel_mode          = take ? cfg_mode : cur_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode.fmt      <= FMT_RGB24;
      cur_mode.per_word <= 4'd2;
    end else if (take) begin
      cur_mode <= cfg_mode;
    end
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cur_mode));
endmodule

// File: rtl/pix_strobe_gen.sv
module pix_strobe_gen #(
  parameter int LANES = pix_unpack_pkg::PP_LANES,
  localparam int PW = $clog2(2 * LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    per_word,
  output logic          load_q,
  output logic [PW-1:0] slot
);
  logic [PW-1:0] ph;
  logic [PW-1:0] last_slot;

  always_comb begin
    last_slot = PW'(per_word - 4'd1);
    slot      = load_q ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      load_q <= 1'b1;
    end else begin
      ph     <= slot;
      load_q <= (slot == last_slot);
    end
  end

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    load_q |=> !load_q);
endmodule

// File: rtl/pix_field_sel.sv
module pix_field_sel
  import pix_unpack_pkg::*;
#(
  parameter int LANES  = PP_LANES,
  parameter int LANE_W = PP_LANE_W,
  localparam int CH_W  = LANE_W / 3,
  localparam int PW    = $clog2(2 * LANES),
  localparam int LN_W  = $clog2(LANES)
) (
  input  logic [LANES*LANE_W-1:0] word,
  input  mode_t                   mode,
  input  logic [PW-1:0]           slot,
  output logic [LANE_W-1:0]       rgb,
  output logic [CH_W-1:0]         idx
);
  logic [LANE_W-1:0] lane [LANES];
  logic [LANE_W-1:0] sel;
  logic [LN_W-1:0]   lane_no;
  logic              two_per_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[g*LANE_W +: LANE_W];
  end

  always_comb begin
    two_per_lane = (mode.fmt == FMT_IDX8) && (mode.per_word == 4'(2 * LANES));
    lane_no      = two_per_lane ? slot[LN_W:1] : slot[LN_W-1:0];
    sel          = lane[lane_no];
    rgb          = '0;
    idx          = '0;
    case (mode.fmt)
      FMT_RGB24: rgb = sel;
      FMT_RGB16: rgb = {sel[15:11], sel[15:13],
                        sel[10:5],  sel[10:9],
                        sel[4:0],   sel[4:2]};
      FMT_RGB15: rgb = {sel[14:10], sel[14:12],
                        sel[9:5],   sel[9:7],
                        sel[4:0],   sel[4:2]};
      default:   idx = (two_per_lane && slot[0]) ? sel[2*CH_W-1:CH_W]
                                                 : sel[3*CH_W-1:2*CH_W];
    endcase
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int LANES  = PP_LANES,
  parameter int LANE_W = PP_LANE_W,
  localparam int CH_W  = LANE_W / 3,
  localparam int PW    = $clog2(2 * LANES),
  localparam int WW    = LANES * LANE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_fmt,
  input  logic [1:0]      cfg_ratio,
  input  logic [WW-1:0]   word_in,
  output logic            load_o,
  output logic            pix_valid_o,
  output logic [LANE_W-1:0] pix_rgb_o,
  output logic [CH_W-1:0]   pix_idx_o
);
  mode_t             sel_mode;
  mode_t             cur_mode;
  logic [PW-1:0]     slot;
  logic [WW-1:0]     held_word;
  logic [WW-1:0]     src_word;
  logic [LANE_W-1:0] nxt_rgb;
  logic [CH_W-1:0]   nxt_idx;

  pix_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .take      (load_o),
    .cfg_fmt   (cfg_fmt),
    .cfg_ratio (cfg_ratio),
    .sel_mode  (sel_mode),
    .cur_mode  (cur_mode)
  );

  pix_strobe_gen #(.LANES(LANES)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .per_word (sel_mode.per_word),
    .load_q   (load_o),
    .slot     (slot)
  );

  assign src_word = load_o ? word_in : held_word;

  pix_field_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_sel (
    .word (src_word),
    .mode (sel_mode),
    .slot (slot),
    .rgb  (nxt_rgb),
    .idx  (nxt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held_word   <= '0;
      pix_valid_o <= 1'b0;
      pix_rgb_o   <= '0;
      pix_idx_o   <= '0;
    end else begin
      if (load_o) held_word <= word_in;
      pix_valid_o <= 1'b1;
      pix_rgb_o   <= nxt_rgb;
      pix_idx_o   <= nxt_idx;
    end
  end

  // R11
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |=> pix_valid_o);

  // R9
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> (pix_rgb_o == '0 || pix_idx_o == '0));

  // R9
  idx_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid_o && cur_mode.fmt == FMT_IDX8) |-> pix_rgb_o == '0);

  // R3
  per_word_chk: assert property (@(posedge clk) disable iff (rst)
    cur_mode.per_word == 4'd2 || cur_mode.per_word == 4'd4 ||
    (cur_mode.per_word == 4'd8 && cur_mode.fmt == FMT_IDX8));
endmodule

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [1:0]  cfg_ratio = 2'd0;
  logic [95:0] word_in = '0;
  logic        load_o;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;
  logic [7:0]  pix_idx_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pix_unpack u_dut (
    .clk         (clk),
    .rst         (rst),
    .cfg_fmt     (cfg_fmt),
    .cfg_ratio   (cfg_ratio),
    .word_in     (word_in),
    .load_o      (load_o),
    .pix_valid_o (pix_valid_o),
    .pix_rgb_o   (pix_rgb_o),
    .pix_idx_o   (pix_idx_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int n_of(input logic [1:0] f, input logic [1:0] r);
    if (r == 2'd1) return 4;
    if (r == 2'd2) return (f == 2'd3) ? 8 : 4;
    return 2;
  endfunction

  function automatic logic [7:0] wide5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] wide6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // expected {rgb, idx} for pixel k of word w
  function automatic logic [31:0] expect_pix(input logic [95:0] w, input logic [1:0] f,
                                             input logic [1:0] r, input int k);
    logic [23:0] ln;
    logic [23:0] rgb;
    logic [7:0]  ix;
    int n;
    n   = n_of(f, r);
    rgb = '0;
    ix  = '0;
    if (f == 2'd3 && n == 8) begin
      ln = w[(k/2)*24 +: 24];
      ix = (k % 2 == 0) ? ln[23:16] : ln[15:8];
    end else begin
      ln = w[k*24 +: 24];
      case (f)
        2'd0: rgb = ln;
        2'd1: rgb = {wide5(ln[15:11]), wide6(ln[10:5]), wide5(ln[4:0])};
        2'd2: rgb = {wide5(ln[14:10]), wide5(ln[9:5]), wide5(ln[4:0])};
        default: ix = ln[23:16];
      endcase
    end
    return {rgb, ix};
  endfunction

  // one word: drive at a strobe cycle, scramble inputs after pixel 0, check all pixels
  task automatic run_word(input string tag, input logic [1:0] f, input logic [1:0] r,
                          input logic [95:0] w);
    int n;
    n = n_of(f, r);
    while (!load_o) @(negedge clk);
    cfg_fmt   = f;
    cfg_ratio = r;
    word_in   = w;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check({tag, " R11 valid"}, {31'd0, pix_valid_o}, 32'd1);
      check({tag, " R2 pixel"}, {pix_rgb_o, pix_idx_o}, expect_pix(w, f, r, k));
      check({tag, " R4 strobe"}, {31'd0, load_o}, {31'd0, (k == n - 1)});
      if (k == 0) begin
        // R10: inputs away from the strobe edge are ignored
        word_in   = ~w;
        cfg_fmt   = f ^ 2'd3;
        cfg_ratio = r ^ 2'd1;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", {31'd0, pix_valid_o}, 32'd0);
    check("R1 strobe", {31'd0, load_o}, 32'd1);
    check("R1 data", {pix_rgb_o, pix_idx_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_rgb24();
    run_word("R5 24b 4:1", 2'd0, 2'd1, 96'h123456_abcdef_00ff80_7f0102);
    run_word("R5 24b 2:1", 2'd0, 2'd0, 96'hdeadbe_efcafe_a1b2c3_d4e5f6);
  endtask

  task automatic t_rgb16();
    run_word("R6 16b 4:1", 2'd1, 2'd1, 96'h00f81f_0007e0_00ffff_008421);
    run_word("R6 16b 2:1", 2'd1, 2'd0, 96'h000000_000000_55a5c3_33_1234);
  endtask

  task automatic t_rgb15();
    run_word("R7 15b 4:1", 2'd2, 2'd1, 96'hff7c00_0003e0_ff801f_0a5294);
    run_word("R7 15b 2:1", 2'd2, 2'd0, 96'h111111_222222_337fff_444210);
  endtask

  task automatic t_index();
    run_word("R8 idx 8:1", 2'd3, 2'd2, 96'h0102ff_0304ee_0506dd_0708cc);
    run_word("R8 idx 4:1", 2'd3, 2'd1, 96'h90aabb_a0ccdd_b0eeff_c01122);
    run_word("R8 idx 2:1", 2'd3, 2'd0, 96'h000000_000000_fe0000_7f0000);
  endtask

  task automatic t_ratio_codes();
    run_word("R3 24b code2 as 4:1", 2'd0, 2'd2, 96'h010203_040506_070809_0a0b0c);
    run_word("R3 code3 as 2:1", 2'd3, 2'd3, 96'h000000_000000_5a0000_a50000);
    run_word("R3 16b code3", 2'd1, 2'd3, 96'h000000_000000_00abcd_00ef01);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rgb24();
        t_index();
        t_rgb16();
        t_ratio_codes();
        t_rgb15();
        run_word("R10 back to back 8:1", 2'd3, 2'd2, 96'hfedcba_987654_321012_345678);
      end
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule